// File: doc/BRIEF.md
# Variable Range Pair Encoder and Checker

This unit translates between a page-granular memory range description (start page, length in pages, 8-bit memory attribute) and the pair of 32-bit-plus-high-word registers that describe a variable memory range: a base word pair that carries the start page and the attribute, and a mask word pair that carries the negated length and a valid flag. An encode request checks that the range is a naturally aligned power-of-two span and builds both register pairs. A zero length produces all-zero words, which disables the range. A decode request takes a stored pair and returns the start page, the length and the attribute. If the high part of the mask has been left incomplete, the unit fills in its upper ones and flags the repair.

Both directions share one request/done handshake. A request is accepted in any cycle, and its result appears with a one-cycle `done` pulse exactly two cycles later. Results stay on the outputs until the next `done`. Next to the codec, a purely combinational slot picker turns a vector of per-slot valid bits into the index to program next. It honours an explicit replacement index when that index is in range.

All addresses are page numbers of 4 KiB pages. `PHYS_W` is the implemented physical address width (more than 32), so a page number has `PN_W = PHYS_W-12` bits, of which the low 20 sit in the low register word and the remaining `HI_W = PHYS_W-32` in the high word.

Top module: `vrp_codec`

## Requirements
- R1: `done` is high for exactly one cycle, two clock cycles after the cycle in which `req_valid` was sampled high; requests in consecutive cycles each get their own `done` in order.
- R2: For an aligned encode with nonzero length, `wr_base_lo` = {page[19:0], 4'b0000, attr} and `wr_base_hi` = page[PN_W-1:20].
- R3: For an aligned encode with nonzero length, with N = (2^PN_W − length) mod 2^PN_W, `wr_mask_lo` = {N[19:0], 12'h800} (bit 11 is the valid flag) and `wr_mask_hi` = N[PN_W-1:20].
- R4: An encode with length zero gives all four register words zero and `align_err` low.
- R5: An encode with nonzero length raises `align_err` exactly when the range is not aligned. The test repeatedly shifts start and last = start+length−1 right while start's LSB is 0 and last's LSB is 1, and fails if the two values then differ; a range running past the address space fails. On error all four words are zero.
- R6: A decode whose `rd_mask_lo` bit 11 is clear returns page, length and attribute zero and `mask_repaired` low.
- R7: A valid decode returns page = {rd_base_hi, rd_base_lo[31:12]} and attribute = rd_base_lo[7:0]; rd_base_lo[11:8] and rd_mask_lo[10:0] have no effect.
- R8: On a valid decode, with M = {rd_mask_hi, rd_mask_lo[31:12]}, every bit from the highest set bit of M up to bit PN_W−1 is forced to one; `mask_repaired` is high exactly when this changes M. A zero M stays zero.
- R9: The decoded length is (2^PN_W − repaired M) mod 2^PN_W.
- R10: After an encode the decode outputs are zero, and after a decode the encode outputs and `align_err` are zero; between `done` pulses all result outputs hold their values regardless of input changes.
- R11: When `repl_en` is high and `repl_idx` < SLOTS, `free_idx` = `repl_idx` and `free_none` is low, whatever `slot_live` holds.
- R12: Otherwise `free_idx` is the lowest slot whose `slot_live` bit is 0 with `free_none` low; if every bit is 1, `free_none` is high and `free_idx` is 0.
- R13: While reset is applied, `done` and every result output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_decode | input | 1 | 0 = encode, 1 = decode |
| enc_page | input | PN_W | Start page to encode |
| enc_pages | input | PN_W | Length in pages to encode (0 = disable) |
| enc_attr | input | 8 | Attribute to encode |
| rd_base_lo | input | 32 | Stored base word, low |
| rd_base_hi | input | HI_W | Stored base word, high |
| rd_mask_lo | input | 32 | Stored mask word, low |
| rd_mask_hi | input | HI_W | Stored mask word, high |
| done | output | 1 | Result valid pulse |
| wr_base_lo | output | 32 | Encoded base word, low |
| wr_base_hi | output | HI_W | Encoded base word, high |
| wr_mask_lo | output | 32 | Encoded mask word, low |
| wr_mask_hi | output | HI_W | Encoded mask word, high |
| align_err | output | 1 | Encode range not aligned |
| dec_page | output | PN_W | Decoded start page |
| dec_pages | output | PN_W | Decoded length in pages |
| dec_attr | output | 8 | Decoded attribute |
| mask_repaired | output | 1 | Decoded mask needed its upper bits filled |
| slot_live | input | SLOTS | Per-slot valid bits |
| repl_en | input | 1 | Use the replacement index |
| repl_idx | input | IDX_W+1 | Requested replacement slot |
| free_idx | output | IDX_W | Chosen slot |
| free_none | output | 1 | No slot available |

## Verification
Encode is swept over every start page and length from 0 to 63 pages, plus large spans near the top of the address space. This separates aligned power-of-two ranges from odd lengths, misaligned starts and overflowing ranges, and it exercises the high-word split. Decode is driven with well-formed masks of every size, masks with only their top bits missing (which must be repaired), masks with holes below the top set bit (which must be left alone), a zero mask, and cleared valid bits carrying junk, with junk also placed in the ignored base and mask bits. The slot picker sees all 256 live patterns and every in-range and out-of-range replacement index. Back-to-back requests and input changes between requests show the two-cycle timing and that results are held.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int LO_PN_W    = 32 - PAGE_SHIFT;
  localparam int ATTR_W     = 8;
  localparam int VALID_BIT  = 11;

  typedef enum logic {
    OP_ENCODE = 1'b0,
    OP_DECODE = 1'b1
  } vrp_op_e;
endpackage

// File: rtl/vrp_encoder.sv
module vrp_encoder
  import vrp_pkg::*;
#(
  parameter int PN_W = 24,
  parameter int HI_W = 4
) (
  input  logic [PN_W-1:0]   page,
  input  logic [PN_W-1:0]   pages,
  input  logic [ATTR_W-1:0] attr,
  output logic [31:0]       base_lo,
  output logic [HI_W-1:0]   base_hi,
  output logic [31:0]       mask_lo,
  output logic [HI_W-1:0]   mask_hi,
  output logic              err
);
  logic [PN_W:0]   start_w;
  logic [PN_W:0]   last_w;
  logic [PN_W+1:0] run;
  logic [PN_W:0]   bit_ok;
  logic [PN_W-1:0] neg;
  logic            aligned;

  assign start_w = {1'b0, page};
  assign last_w  = {1'b0, page} + {1'b0, pages} - 1'b1;
  assign neg     = ~pages + 1'b1;

  // Trailing run of (start bit 0, last bit 1) positions is shifted away;
  // every position above that run must agree.
  always_comb begin
    run[0] = 1'b1;
    for (int i = 0; i <= PN_W; i++) begin
      run[i+1]  = run[i] & ~start_w[i] & last_w[i];
      bit_ok[i] = run[i+1] | ~(start_w[i] ^ last_w[i]);
    end
  end

  assign aligned = &bit_ok;

  always_comb begin
    base_lo = '0;
    base_hi = '0;
    mask_lo = '0;
    mask_hi = '0;
    err     = 1'b0;
    if (pages != '0) begin
      if (!aligned) begin
        err = 1'b1;
      end else begin
        base_lo = {page[LO_PN_W-1:0], 4'b0000, attr};
        base_hi = page[PN_W-1:LO_PN_W];
        mask_lo = {neg[LO_PN_W-1:0], 12'h800};
        mask_hi = neg[PN_W-1:LO_PN_W];
      end
    end
  end
endmodule

// File: rtl/vrp_decoder.sv
module vrp_decoder
  import vrp_pkg::*;
#(
  parameter int PN_W = 24,
  parameter int HI_W = 4
) (
  input  logic [31:0]       base_lo,
  input  logic [HI_W-1:0]   base_hi,
  input  logic [31:0]       mask_lo,
  input  logic [HI_W-1:0]   mask_hi,
  output logic [PN_W-1:0]   page,
  output logic [PN_W-1:0]   pages,
  output logic [ATTR_W-1:0] attr,
  output logic              repaired
);
  logic [PN_W-1:0] raw;
  logic [PN_W-1:0] above;
  logic [PN_W-1:0] ext;
  logic            any_set;
  logic            unused_bits;

  assign raw         = {mask_hi, mask_lo[31:PAGE_SHIFT]};
  assign any_set     = |raw;
  assign unused_bits = ^{mask_lo[VALID_BIT-1:0], base_lo[PAGE_SHIFT-1:ATTR_W]};

  // above[i] is set when some mask bit strictly higher than i is set.
  always_comb begin
    above[PN_W-1] = 1'b0;
    for (int i = PN_W - 2; i >= 0; i--) begin
      above[i] = above[i+1] | raw[i+1];
    end
  end

  assign ext = raw | ({PN_W{any_set}} & ~above);

  always_comb begin
    page     = '0;
    pages    = '0;
    attr     = '0;
    repaired = 1'b0;
    if (mask_lo[VALID_BIT]) begin
      page     = {base_hi, base_lo[31:PAGE_SHIFT]};
      pages    = ~ext + 1'b1;
      attr     = base_lo[ATTR_W-1:0];
      repaired = (ext != raw);
    end
  end
endmodule

// File: rtl/vrp_slot_pick.sv
module vrp_slot_pick #(
  parameter int SLOTS = 8,
  parameter int IDX_W = 3
) (
  input  logic [SLOTS-1:0] live,
  input  logic             repl_en,
  input  logic [IDX_W:0]   repl_idx,
  output logic [IDX_W-1:0] idx,
  output logic             none
);
  localparam logic [IDX_W:0] SLOTS_V = (IDX_W + 1)'(SLOTS);

  always_comb begin
    idx  = '0;
    none = 1'b1;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!live[i]) begin
        idx  = IDX_W'(i);
        none = 1'b0;
      end
    end
    if (repl_en && (repl_idx < SLOTS_V)) begin
      idx  = repl_idx[IDX_W-1:0];
      none = 1'b0;
    end
  end
endmodule

// File: rtl/vrp_codec.sv
module vrp_codec
  import vrp_pkg::*;
#(
  parameter  int PHYS_W = 36,
  parameter  int SLOTS  = 8,
  localparam int PN_W   = PHYS_W - PAGE_SHIFT,
  localparam int HI_W   = PHYS_W - 32,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_decode,
  input  logic [PN_W-1:0]   enc_page,
  input  logic [PN_W-1:0]   enc_pages,
  input  logic [ATTR_W-1:0] enc_attr,
  input  logic [31:0]       rd_base_lo,
  input  logic [HI_W-1:0]   rd_base_hi,
  input  logic [31:0]       rd_mask_lo,
  input  logic [HI_W-1:0]   rd_mask_hi,
  output logic              done,
  output logic [31:0]       wr_base_lo,
  output logic [HI_W-1:0]   wr_base_hi,
  output logic [31:0]       wr_mask_lo,
  output logic [HI_W-1:0]   wr_mask_hi,
  output logic              align_err,
  output logic [PN_W-1:0]   dec_page,
  output logic [PN_W-1:0]   dec_pages,
  output logic [ATTR_W-1:0] dec_attr,
  output logic              mask_repaired,
  input  logic [SLOTS-1:0]  slot_live,
  input  logic              repl_en,
  input  logic [IDX_W:0]    repl_idx,
  output logic [IDX_W-1:0]  free_idx,
  output logic              free_none
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  // stage 1: captured request
  logic              s1_vld;
  vrp_op_e           s1_op;
  logic [PN_W-1:0]   s1_page, s1_pages;
  logic [ATTR_W-1:0] s1_attr;
  logic [31:0]       s1_blo, s1_mlo;
  logic [HI_W-1:0]   s1_bhi, s1_mhi;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      s1_vld   <= 1'b0;
      s1_op    <= OP_ENCODE;
      s1_page  <= '0;
      s1_pages <= '0;
      s1_attr  <= '0;
      s1_blo   <= '0;
      s1_bhi   <= '0;
      s1_mlo   <= '0;
      s1_mhi   <= '0;
    end else begin
      s1_vld <= req_valid;
      if (req_valid) begin
        s1_op    <= vrp_op_e'(req_decode);
        s1_page  <= enc_page;
        s1_pages <= enc_pages;
        s1_attr  <= enc_attr;
        s1_blo   <= rd_base_lo;
        s1_bhi   <= rd_base_hi;
        s1_mlo   <= rd_mask_lo;
        s1_mhi   <= rd_mask_hi;
      end
    end
  end

  // conversion datapaths
  logic [31:0]       e_blo, e_mlo;
  logic [HI_W-1:0]   e_bhi, e_mhi;
  logic              e_err;
  logic [PN_W-1:0]   d_page, d_pages;
  logic [ATTR_W-1:0] d_attr;
  logic              d_rep;

  vrp_encoder #(.PN_W(PN_W), .HI_W(HI_W)) u_enc (
    .page(s1_page), .pages(s1_pages), .attr(s1_attr),
    .base_lo(e_blo), .base_hi(e_bhi), .mask_lo(e_mlo), .mask_hi(e_mhi),
    .err(e_err)
  );

  vrp_decoder #(.PN_W(PN_W), .HI_W(HI_W)) u_dec (
    .base_lo(s1_blo), .base_hi(s1_bhi), .mask_lo(s1_mlo), .mask_hi(s1_mhi),
    .page(d_page), .pages(d_pages), .attr(d_attr), .repaired(d_rep)
  );

  // stage 2: result selection (next state)
  logic [31:0]       n_blo, n_mlo;
  logic [HI_W-1:0]   n_bhi, n_mhi;
  logic              n_err, n_rep;
  logic [PN_W-1:0]   n_page, n_pages;
  logic [ATTR_W-1:0] n_attr;

  always_comb begin
    n_blo   = '0;
    n_bhi   = '0;
    n_mlo   = '0;
    n_mhi   = '0;
    n_err   = 1'b0;
    n_page  = '0;
    n_pages = '0;
    n_attr  = '0;
    n_rep   = 1'b0;
    if (s1_op == OP_DECODE) begin
      n_page  = d_page;
      n_pages = d_pages;
      n_attr  = d_attr;
      n_rep   = d_rep;
    end else begin
      n_blo = e_blo;
      n_bhi = e_bhi;
      n_mlo = e_mlo;
      n_mhi = e_mhi;
      n_err = e_err;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done          <= 1'b0;
      wr_base_lo    <= '0;
      wr_base_hi    <= '0;
      wr_mask_lo    <= '0;
      wr_mask_hi    <= '0;
      align_err     <= 1'b0;
      dec_page      <= '0;
      dec_pages     <= '0;
      dec_attr      <= '0;
      mask_repaired <= 1'b0;
    end else begin
      done <= s1_vld;
      if (s1_vld) begin
        wr_base_lo    <= n_blo;
        wr_base_hi    <= n_bhi;
        wr_mask_lo    <= n_mlo;
        wr_mask_hi    <= n_mhi;
        align_err     <= n_err;
        dec_page      <= n_page;
        dec_pages     <= n_pages;
        dec_attr      <= n_attr;
        mask_repaired <= n_rep;
      end
    end
  end

  vrp_slot_pick #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_pick (
    .live(slot_live), .repl_en(repl_en), .repl_idx(repl_idx),
    .idx(free_idx), .none(free_none)
  );
endmodule

// File: rtl/vrp_codec_chk.sv
module vrp_codec_chk #(
  parameter  int PHYS_W = 36,
  parameter  int SLOTS  = 8,
  localparam int PN_W   = PHYS_W - 12,
  localparam int HI_W   = PHYS_W - 32,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_decode,
  input logic [PN_W-1:0]  enc_pages,
  input logic [31:0]      rd_mask_lo,
  input logic             done,
  input logic [31:0]      wr_base_lo,
  input logic [HI_W-1:0]  wr_base_hi,
  input logic [31:0]      wr_mask_lo,
  input logic [HI_W-1:0]  wr_mask_hi,
  input logic             align_err,
  input logic [PN_W-1:0]  dec_page,
  input logic [PN_W-1:0]  dec_pages,
  input logic [7:0]       dec_attr,
  input logic             mask_repaired,
  input logic [SLOTS-1:0] slot_live,
  input logic             repl_en,
  input logic [IDX_W:0]   repl_idx,
  input logic [IDX_W-1:0] free_idx,
  input logic             free_none
);
  localparam logic [IDX_W:0] SLOTS_V = (IDX_W + 1)'(SLOTS);

  p_done_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 done);

  p_done_has_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid, 2));

  p_zero_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(req_decode, 2) && ($past(enc_pages, 2) == '0)) |->
    (wr_base_lo == '0 && wr_base_hi == '0 && wr_mask_lo == '0 &&
     wr_mask_hi == '0 && !align_err));

  p_err_clears_words_r5: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (wr_base_lo == '0 && wr_mask_lo == '0 &&
                   wr_base_hi == '0 && wr_mask_hi == '0));

  p_invalid_decode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(req_decode, 2) && !$past(rd_mask_lo[11], 2)) |->
    (dec_page == '0 && dec_pages == '0 && dec_attr == '0 && !mask_repaired));

  p_decode_clears_enc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(req_decode, 2)) |-> (wr_mask_lo == '0 && !align_err));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(dec_pages) && $stable(wr_mask_lo) && $stable(align_err)));

  p_replace_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_en && repl_idx < SLOTS_V) |->
    ({1'b0, free_idx} == repl_idx && !free_none));

  p_lowest_free_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_none && !(repl_en && repl_idx < SLOTS_V)) |-> !slot_live[free_idx]);

  p_none_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    free_none |-> (&slot_live));
endmodule

bind vrp_codec vrp_codec_chk #(.PHYS_W(PHYS_W), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_decode(req_decode),
  .enc_pages(enc_pages), .rd_mask_lo(rd_mask_lo), .done(done),
  .wr_base_lo(wr_base_lo), .wr_base_hi(wr_base_hi), .wr_mask_lo(wr_mask_lo),
  .wr_mask_hi(wr_mask_hi), .align_err(align_err), .dec_page(dec_page),
  .dec_pages(dec_pages), .dec_attr(dec_attr), .mask_repaired(mask_repaired),
  .slot_live(slot_live), .repl_en(repl_en), .repl_idx(repl_idx),
  .free_idx(free_idx), .free_none(free_none)
);

// File: tb/vrp_codec_tb.sv
module vrp_codec_tb_top;
  localparam int PHYS_W = 34;
  localparam int SLOTS  = 8;
  localparam int PN_W   = PHYS_W - 12;
  localparam int HI_W   = PHYS_W - 32;
  localparam int IDX_W  = 3;
  localparam logic [63:0] PMASK = (64'd1 << PN_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_decode = 1'b0;
  logic [PN_W-1:0] enc_page = '0, enc_pages = '0;
  logic [7:0] enc_attr = '0;
  logic [31:0] rd_base_lo = '0, rd_mask_lo = '0;
  logic [HI_W-1:0] rd_base_hi = '0, rd_mask_hi = '0;
  logic done, align_err, mask_repaired, free_none;
  logic [31:0] wr_base_lo, wr_mask_lo;
  logic [HI_W-1:0] wr_base_hi, wr_mask_hi;
  logic [PN_W-1:0] dec_page, dec_pages;
  logic [7:0] dec_attr;
  logic [SLOTS-1:0] slot_live = '0;
  logic repl_en = 1'b0;
  logic [IDX_W:0] repl_idx = '0;
  logic [IDX_W-1:0] free_idx;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  vrp_codec #(.PHYS_W(PHYS_W), .SLOTS(SLOTS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_decode(req_decode),
    .enc_page(enc_page), .enc_pages(enc_pages), .enc_attr(enc_attr),
    .rd_base_lo(rd_base_lo), .rd_base_hi(rd_base_hi),
    .rd_mask_lo(rd_mask_lo), .rd_mask_hi(rd_mask_hi),
    .done(done), .wr_base_lo(wr_base_lo), .wr_base_hi(wr_base_hi),
    .wr_mask_lo(wr_mask_lo), .wr_mask_hi(wr_mask_hi), .align_err(align_err),
    .dec_page(dec_page), .dec_pages(dec_pages), .dec_attr(dec_attr),
    .mask_repaired(mask_repaired), .slot_live(slot_live), .repl_en(repl_en),
    .repl_idx(repl_idx), .free_idx(free_idx), .free_none(free_none)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit ref_aligned(input logic [63:0] b, input logic [63:0] s);
    logic [63:0] lb = b;
    logic [63:0] la = b + s - 1;
    while (!lb[0] && la[0]) begin
      lb = lb >> 1;
      la = la >> 1;
    end
    return lb == la;
  endfunction

  task automatic run_enc(input logic [63:0] b, input logic [63:0] s, input logic [7:0] a);
    logic [63:0] neg;
    bit ok;
    @(negedge clk);
    req_valid = 1'b1; req_decode = 1'b0;
    enc_page = b[PN_W-1:0]; enc_pages = s[PN_W-1:0]; enc_attr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 early", {63'd0, done}, 64'd0);
    @(negedge clk);
    chk("R1", {63'd0, done}, 64'd1);
    neg = ((64'd1 << PN_W) - s) & PMASK;
    ok  = ref_aligned(b, s);
    chk("R10 dec zero", {40'd0, dec_pages}, 64'd0);
    if (s == 0) begin
      chk("R4 words", {wr_base_lo, wr_mask_lo}, 64'd0);
      chk("R4 hi", {60'd0, wr_base_hi, wr_mask_hi}, 64'd0);
      chk("R4 err", {63'd0, align_err}, 64'd0);
    end else if (!ok) begin
      chk("R5 err", {63'd0, align_err}, 64'd1);
      chk("R5 words", {wr_base_lo, wr_mask_lo}, 64'd0);
    end else begin
      chk("R5 no err", {63'd0, align_err}, 64'd0);
      chk("R2 lo", {32'd0, wr_base_lo}, ((b & 64'hFFFFF) << 12) | a);
      chk("R2 hi", {62'd0, wr_base_hi}, b >> 20);
      chk("R3 lo", {32'd0, wr_mask_lo}, ((neg & 64'hFFFFF) << 12) | 64'h800);
      chk("R3 hi", {62'd0, wr_mask_hi}, neg >> 20);
    end
  endtask

  task automatic run_dec(input logic [63:0] raw, input bit vld, input logic [63:0] b,
                         input logic [7:0] a, input logic [10:0] junk);
    logic [63:0] ext;
    int h;
    @(negedge clk);
    req_valid  = 1'b1; req_decode = 1'b1;
    rd_base_lo = {b[19:0], junk[3:0], a};
    rd_base_hi = b[PN_W-1:20];
    rd_mask_lo = {raw[19:0], vld, junk};
    rd_mask_hi = raw[PN_W-1:20];
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1", {63'd0, done}, 64'd1);
    chk("R10 enc zero", {32'd0, wr_mask_lo}, 64'd0);
    if (!vld) begin
      chk("R6 outs", {dec_page, dec_pages, dec_attr, 11'd0, mask_repaired}, 64'd0);
    end else begin
      ext = raw & PMASK;
      h = -1;
      for (int i = 0; i < PN_W; i++) if (raw[i]) h = i;
      if (h >= 0) ext = ext | (PMASK & ~((64'd1 << h) - 1));
      chk("R7 page", {40'd0, dec_page}, b & PMASK);
      chk("R7 attr", {56'd0, dec_attr}, {56'd0, a});
      chk("R8 flag", {63'd0, mask_repaired}, {63'd0, (ext != (raw & PMASK))});
      chk("R9 size", {40'd0, dec_pages}, ((64'd1 << PN_W) - ext) & PMASK);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset values
    chk("R13 done", {63'd0, done}, 64'd0);
    chk("R13 words", {wr_base_lo, wr_mask_lo}, 64'd0);
    chk("R13 dec", {40'd0, dec_pages}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // encode sweep (R2 R3 R4 R5)
    for (int b = 0; b < 64; b++)
      for (int s = 0; s < 64; s++)
        run_enc(64'(b), 64'(s), 8'((b * 37 + s * 11) & 255));
    run_enc(64'h200000, 64'h200000, 8'h06);
    run_enc(64'h300000, 64'h200000, 8'h06);
    run_enc(64'h300000, 64'h100000, 8'h01);
    run_enc(64'h0, 64'h3FFFFF, 8'h05);
    run_enc(64'h3FF000, 64'h1000, 8'h04);
    run_enc(64'h3FFFFF, 64'h1, 8'hFF);
    run_enc(64'h3FFFFF, 64'h2, 8'h00);

    // decode sweep (R6 R7 R8 R9)
    for (int h = 0; h < PN_W; h++) begin
      logic [63:0] low;
      low = (64'd1 << h) - 1;
      run_dec(PMASK & ~low, 1'b1, 64'(h * 4099), 8'(h * 13), 11'h7FF);
      run_dec(64'd1 << h, 1'b1, 64'h2ABCDE, 8'h06, 11'h0F3);
      run_dec((64'd1 << h) | (low & 64'h155555), 1'b1, 64'h1234, 8'h01, 11'h000);
      run_dec(PMASK & ~low, 1'b0, 64'h3FFFFF, 8'hAA, 11'h5A5);
    end
    run_dec(64'h0, 1'b1, 64'h10, 8'h04, 11'h100);
    run_dec(64'h3F0F00, 1'b1, 64'h77, 8'h05, 11'h000);

    // back-to-back requests (R1)
    @(negedge clk);
    req_valid = 1'b1; req_decode = 1'b0; enc_page = 22'h40; enc_pages = 22'h40; enc_attr = 8'h06;
    @(negedge clk);
    req_decode = 1'b1; rd_base_lo = 32'h0005_5006; rd_base_hi = '0;
    rd_mask_lo = 32'hFFFF_F800; rd_mask_hi = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 b2b first", {63'd0, done}, 64'd1);
    chk("R1 b2b first data", {32'd0, wr_base_lo}, 64'h0004_0006);
    @(negedge clk);
    chk("R1 b2b second", {63'd0, done}, 64'd1);
    chk("R1 b2b second data", {40'd0, dec_pages}, 64'd1);
    chk("R10 after decode", {63'd0, align_err}, 64'd0);
    @(negedge clk);
    chk("R1 pulse ends", {63'd0, done}, 64'd0);

    // hold without request (R10)
    rd_mask_lo = 32'h0; enc_pages = 22'h3; req_decode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 hold pages", {40'd0, dec_pages}, 64'd1);
    chk("R10 hold page", {40'd0, dec_page}, 64'h55);
    chk("R10 hold done", {63'd0, done}, 64'd0);

    // slot picker (R11 R12)
    for (int v = 0; v < 256; v++) begin
      int lowest;
      @(negedge clk);
      slot_live = 8'(v); repl_en = 1'b0; repl_idx = 4'(v & 15);
      #1;
      lowest = -1;
      for (int i = 7; i >= 0; i--) if (!v[i]) lowest = i;
      if (lowest < 0) begin
        chk("R12 none", {60'd0, free_none, free_idx}, {60'd0, 4'b1000});
      end else begin
        chk("R12 lowest", {60'd0, free_none, free_idx}, 64'(lowest));
      end
    end
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      slot_live = 8'hFF; repl_en = 1'b1; repl_idx = 4'(r);
      #1;
      if (r < SLOTS) chk("R11 replace", {60'd0, free_none, free_idx}, 64'(r));
      else chk("R12 out of range full", {63'd0, free_none}, 64'd1);
      slot_live = 8'b1011_0111;
      #1;
      if (r < SLOTS) chk("R11 replace live", {60'd0, free_none, free_idx}, 64'(r));
      else chk("R12 out of range", {60'd0, free_none, free_idx}, 64'd3);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule